// File: doc/BRIEF.md
# Axis New-Data Status Register

This block holds the new-sample status of a three-axis acceleration front end in a single readable byte. Each axis raises its own ready bit when the acquisition logic pulses that axis's completion strobe. A host clears the bits as a side effect of reading the axis high-byte output registers. The block sees those reads as a read strobe with an address. Writing the status byte is not a clear path.

A summary bit reports that a fresh sample set is waiting on any enabled channel. Only a completion strobe on an enabled channel raises it. It clears only after the host has read all three high-byte registers, in any order, since it was last raised. When a completion and a clearing read land in the same cycle, the completion wins and the bit stays set.

Top module: `axis_ready_flags`

## Requirements
- R1: After reset, `status` reads 0x00.
- R2: A pulse on `acq_done[i]` sets status bit i one cycle later. Bit 0 is X, bit 1 is Y and bit 2 is Z. This happens whether or not the channel is enabled.
- R3: A read at the high-byte address of axis i clears status bit i one cycle later and leaves the other bits unchanged. The addresses are X 0x01, Y 0x03 and Z 0x05.
- R4: When a completion and a clearing read for the same flag occur in one cycle, that flag is 1 in the next cycle.
- R5: A completion on any channel whose `ch_en` bit is 1 sets status bit 3, the summary flag, one cycle later.
- R6: The summary flag clears in the cycle after the last of the three high-byte reads since it was set, in any order. It stays 1 while any of those reads is missing.
- R7: An enabled completion while the summary flag is already set restarts its read tracking. High-byte reads made before that completion no longer count toward clearing.
- R8: A completion on a channel whose `ch_en` bit is 0 does not set the summary flag.
- R9: A read of the status address 0x00, or of any other address that is not a high-byte address, changes no flag. Status bits 7:4 are always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acq_done | input | 3 | Per-axis acquisition completion strobes {Z,Y,X} |
| ch_en | input | 3 | Per-axis channel enables {Z,Y,X} |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Register read address |
| status | output | 8 | Status byte {0000, summary, Z, Y, X} |

## Verification
The state lives entirely in flags that are visible on `status`, plus a hidden three-bit record of which high-byte reads are still owed. A wrong axis flag therefore shows on `status` in the cycle after the strobe or read that caused it. A wrong read record stays hidden until the read sequence ends: the summary bit then clears one read too early or stays stuck after the third read. The bench checks for this by mixing read orders, repeated reads and mid-sequence re-arming.

// File: rtl/axis_ready_flags.sv
module axis_ready_flags #(
  parameter int          ADDR_W  = 8,
  parameter logic [7:0]  ADDR_ST = 8'h00,
  parameter logic [7:0]  ADDR_XM = 8'h01,
  parameter logic [7:0]  ADDR_YM = 8'h03,
  parameter logic [7:0]  ADDR_ZM = 8'h05
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        acq_done,
  input  logic [2:0]        ch_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        status
);

  logic [2:0] axis_rdy;
  logic [2:0] owed;
  logic       any_rdy;
  logic [2:0] rd_hit;
  logic       arm;
  logic [2:0] owed_nxt;

  assign rd_hit[0] = rd_en && (rd_addr == ADDR_W'(ADDR_XM));
  assign rd_hit[1] = rd_en && (rd_addr == ADDR_W'(ADDR_YM));
  assign rd_hit[2] = rd_en && (rd_addr == ADDR_W'(ADDR_ZM));
  assign arm       = |(acq_done & ch_en);
  assign owed_nxt  = owed & ~rd_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      axis_rdy <= '0;
      owed     <= '0;
      any_rdy  <= 1'b0;
    end else begin
      axis_rdy <= acq_done | (axis_rdy & ~rd_hit);
      if (arm) begin
        any_rdy <= 1'b1;
        owed    <= 3'b111;
      end else if (any_rdy) begin
        owed <= owed_nxt;
        if (owed_nxt == 3'b000) any_rdy <= 1'b0;
      end
    end
  end

  assign status = {4'b0000, any_rdy, axis_rdy};

  // R2
  axis_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_done != 3'b000) |=> ((status[2:0] & $past(acq_done)) == $past(acq_done)));

  // R3
  axis_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_hit & ~acq_done) != 3'b000) |=> ((status[2:0] & $past(rd_hit & ~acq_done)) == 3'b000));

  // R5
  sum_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> status[3]);

  // R6
  sum_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[3] && !rd_en) |=> status[3]);

  // R8
  sum_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!status[3] && !arm) |=> !status[3]);

  // R9
  st_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == ADDR_W'(ADDR_ST) && acq_done == 3'b000) |=> $stable(status));

  // R9
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[7:4] == 4'b0000);

endmodule

// File: tb/tb_axis_ready_flags.sv
module tb_axis_ready_flags;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] acq_done = '0;
  logic [2:0] ch_en = '0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_addr = '0;
  logic [7:0] status;

  typedef struct {
    logic [7:0] exp;
    string      req;
  } item_t;

  item_t sb[$];
  int    checks = 0;
  int    errors = 0;
  bit    done = 0;

  logic       mx, my, mz, mc;
  logic [2:0] mo;

  always #5 clk = ~clk;

  axis_ready_flags dut (
    .clk(clk), .rst_n(rst_n), .acq_done(acq_done), .ch_en(ch_en),
    .rd_en(rd_en), .rd_addr(rd_addr), .status(status)
  );

  task automatic step(input logic [2:0] a, input logic [2:0] e,
                      input logic r, input logic [7:0] ad, input string req);
    logic [2:0] hit;
    logic [2:0] ax;
    item_t it;
    @(negedge clk);
    acq_done = a; ch_en = e; rd_en = r; rd_addr = ad;
    hit[0] = r && ad == 8'h01;
    hit[1] = r && ad == 8'h03;
    hit[2] = r && ad == 8'h05;
    ax = {mz, my, mx};
    ax = a | (ax & ~hit);
    if ((a & e) != 0) begin
      mc = 1'b1; mo = 3'b111;
    end else if (mc) begin
      mo = mo & ~hit;
      if (mo == 0) mc = 1'b0;
    end
    {mz, my, mx} = ax;
    @(posedge clk);
    #1;
    acq_done = '0; rd_en = 1'b0;
    it.exp = {4'b0, mc, mz, my, mx};
    it.req = req;
    sb.push_back(it);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        checks++;
        if (status !== it.exp) begin
          errors++;
          $display("FAIL %s: status=%02h expected=%02h", it.req, status, it.exp);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin : watchdog
    #200000;
    errors++;
    $display("FAIL watchdog: status=%02h expected=done", status);
    finish_run();
  end

  initial begin : driver
    mx = 0; my = 0; mz = 0; mc = 0; mo = 0;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    // R1
    if (status !== 8'h00) begin
      errors++;
      $display("FAIL R1: status=%02h expected=00", status);
    end
    @(negedge clk) rst_n = 1'b1;

    step(3'b000, 3'b111, 0, 8'h00, "R1");
    step(3'b001, 3'b000, 0, 8'h00, "R2_R8");
    step(3'b010, 3'b000, 0, 8'h00, "R2_R8");
    step(3'b100, 3'b011, 0, 8'h00, "R8");
    step(3'b000, 3'b000, 1, 8'h03, "R3");
    step(3'b000, 3'b000, 1, 8'h00, "R9");
    step(3'b000, 3'b000, 1, 8'h07, "R9");
    step(3'b000, 3'b000, 1, 8'h02, "R9");
    step(3'b000, 3'b000, 1, 8'h01, "R3");
    step(3'b000, 3'b000, 1, 8'h05, "R3");
    step(3'b010, 3'b010, 0, 8'h00, "R5");
    step(3'b000, 3'b111, 1, 8'h05, "R6");
    step(3'b000, 3'b111, 1, 8'h05, "R6");
    step(3'b000, 3'b111, 1, 8'h01, "R6");
    step(3'b000, 3'b111, 1, 8'h00, "R9");
    step(3'b000, 3'b111, 1, 8'h03, "R6");
    step(3'b000, 3'b111, 0, 8'h00, "R6");
    step(3'b111, 3'b111, 0, 8'h00, "R5");
    step(3'b000, 3'b111, 1, 8'h01, "R6");
    step(3'b000, 3'b111, 1, 8'h03, "R6");
    step(3'b100, 3'b100, 1, 8'h05, "R4_R7");
    step(3'b000, 3'b111, 1, 8'h05, "R7");
    step(3'b000, 3'b111, 1, 8'h01, "R7");
    step(3'b000, 3'b111, 1, 8'h03, "R7");
    step(3'b001, 3'b001, 1, 8'h01, "R4");
    step(3'b000, 3'b111, 1, 8'h01, "R3");
    step(3'b000, 3'b111, 1, 8'h03, "R6");
    step(3'b000, 3'b111, 1, 8'h05, "R6");
    step(3'b010, 3'b101, 1, 8'h03, "R4_R8");
    step(3'b000, 3'b000, 1, 8'h00, "R9");
    step(3'b000, 3'b000, 1, 8'h03, "R3");
    step(3'b000, 3'b000, 0, 8'h00, "R9");
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule